// File: doc/BRIEF.md
# SDRAM Periodic Refresh Sequencer

This block keeps the contents of an SDRAM alive by scheduling and issuing auto-refresh on its own timetable. Once the memory's power-up initialisation has been reported complete, an interval timer starts and, every `PERIOD` clocks, raises a refresh request towards the memory arbiter. A typical setting is about 7.8 µs per refresh. That pace gives 8192 refreshes in 64 ms for commercial parts. Automotive parts need the same count in 16 ms, which is a four times shorter interval. The request stays raised until the arbiter grants it, and the interval timer keeps running regardless of how long the grant takes.

When the grant is accepted, the block takes over the command bus. It closes every bank with a precharge-all and waits the precharge recovery time. It then issues two AUTO REFRESH commands, each followed by the refresh cycle time. It signals completion with a one-clock done pulse and goes back to idle. The memory advances its own refresh row, so the address bus carries zero during refresh. Arbitration between refresh, write and read happens outside this block. Refresh is meant to sit at the top of that priority order.

Top module: `sdram_refresh_seq`

## Requirements
- R1: While reset (`rst_n` low) is sampled, the block drives command NOP (4'b0111, bit order chip-select, row-strobe, column-strobe, write-enable, all active low), address 0, bank 0, `done` low and `ref_req` low.
- R2: `ref_req` stays low until `init_done` has been sampled high. It first rises exactly `PERIOD` clock edges after the edge that sampled `init_done` high.
- R3: The interval timer keeps running after it is armed and sets `ref_req` every `PERIOD` edges. Once set, `ref_req` holds until an accepted grant clears it on the edge that samples the grant.
- R4: A grant sampled while idle with `ref_req` high makes the next cycle's command PRECHARGE (4'b0010) with address bit 10 set, all other address bits 0 and bank 0.
- R5: The first AUTO REFRESH (4'b0001), with address and bank 0, appears `T_RP` cycles after the precharge cycle.
- R6: The second AUTO REFRESH appears `T_RFC` cycles after the first one.
- R7: `done` is high for exactly one cycle, `T_RFC` cycles after the second AUTO REFRESH. The block is idle again on the following cycle.
- R8: In every cycle that is not one of the three command cycles above, the command is NOP with address 0 and bank 0.
- R9: A grant sampled while a sequence is in progress neither restarts the sequence nor clears a pending `ref_req`.
- R10: A grant sampled while `ref_req` is low starts nothing, and the command stays NOP.
- R11: When the timer's terminal count and an accepted grant fall on the same edge, the sequence starts and `ref_req` stays high for the new interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_done | input | 1 | Memory initialisation finished (a pulse or a level) |
| grant | input | 1 | Arbiter hands the command bus to refresh |
| ref_req | output | 1 | Refresh owed, held until granted |
| cmd | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| addr | output | 12 | Address bus (bit 10 selects all banks on precharge) |
| bank | output | 2 | Bank address |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can act on `ref_req` in the same cycle: the interval timer reaching its terminal count, and the arbiter's grant being accepted. The bench waits until a request is pending, the block is idle and the timer is one edge from its terminal count. It then raises the grant so that both are sampled on the same edge. The result is judged correct when the precharge appears on the next cycle and `ref_req` is still high. A second case places the terminal count inside a running sequence and then grants again. That grant must be ignored and the request must survive.

// File: rtl/sdram_rfsh_pkg.sv
// Shared command encodings and sequencer states for the refresh block.
// Assumes the command nibble is {cs_n, ras_n, cas_n, we_n}, all active low.
package sdram_rfsh_pkg;

    typedef enum logic [3:0] {
        CMD_AREF = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_NOP  = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_REF_A = 3'd2,
        ST_REF_B = 3'd3,
        ST_DONE  = 3'd4
    } rf_state_e;

endpackage

// File: rtl/rf_interval_timer.sv
// Interval timer and request latch for periodic refresh.
// Arms once init_done is sampled high, then produces a terminal-count
// tick every PERIOD edges forever. The request is set by the tick and
// cleared by an accepted grant; the tick wins if both coincide.
// Assumes PERIOD >= 2.
module rf_interval_timer #(
    parameter int PERIOD = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_done,
    input  logic accept,
    output logic req
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             req_q;

    // Terminal count of the free-running interval counter
    assign tick = armed_q && (cnt_q == CNT_LAST);

    // Arm on init completion, then wrap the counter every PERIOD edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!armed_q) begin
            if (init_done) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Request latch: set on tick, cleared by an accepted grant
    always_ff @(posedge clk) begin
        if (!rst_n)      req_q <= 1'b0;
        else if (tick)   req_q <= 1'b1;
        else if (accept) req_q <= 1'b0;
    end

    assign req = req_q;

    // R2
    // req_needs_arm_chk: a request can only exist once the timer is armed
    req_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> armed_q);

    // R3
    // req_hold_chk: a pending request survives until a grant is accepted
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !accept) |=> req_q);

endmodule

// File: rtl/rf_step_fsm.sv
// Step sequencer for one refresh episode: precharge-all dwell of T_RP
// cycles, two refresh dwells of T_RFC cycles each, then one done cycle.
// A grant is accepted only when idle and a request is pending.
// Assumes T_RP >= 1 and T_RFC >= 1.
module rf_step_fsm
    import sdram_rfsh_pkg::*;
#(
    parameter int T_RP  = 2,
    parameter int T_RFC = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      grant,
    input  logic      req,
    output logic      accept,
    output rf_state_e state,
    output logic      first
);
    localparam int MAXW = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int W    = $clog2(MAXW + 1);
    localparam logic [W-1:0] RP_LAST  = W'(T_RP - 1);
    localparam logic [W-1:0] RFC_LAST = W'(T_RFC - 1);

    rf_state_e    state_q;
    logic [W-1:0] wcnt_q;

    // Start condition: idle, request pending, arbiter grants
    assign accept = (state_q == ST_IDLE) && grant && req;

    // Walk the states, counting the dwell cycles of each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    wcnt_q <= '0;
                    if (accept) state_q <= ST_PRE;
                end
                ST_PRE: begin
                    if (wcnt_q == RP_LAST) begin
                        state_q <= ST_REF_A;
                        wcnt_q  <= '0;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                ST_REF_A: begin
                    if (wcnt_q == RFC_LAST) begin
                        state_q <= ST_REF_B;
                        wcnt_q  <= '0;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                ST_REF_B: begin
                    if (wcnt_q == RFC_LAST) begin
                        state_q <= ST_DONE;
                        wcnt_q  <= '0;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                    wcnt_q  <= '0;
                end
                default: begin
                    state_q <= ST_IDLE;
                    wcnt_q  <= '0;
                end
            endcase
        end
    end

    assign state = state_q;
    assign first = (wcnt_q == '0);

    // R9
    // no_restart_chk: once busy, the next cycle is never a fresh precharge
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> !(state_q == ST_PRE && wcnt_q == '0));

    // R7
    // done_single_chk: the done step lasts one cycle and returns to idle
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/rf_cmd_drive.sv
// Maps the sequencer step onto the memory command, address and bank.
// A command is issued only on the first cycle of its step; every other
// cycle is NOP with a zero address and bank.
module rf_cmd_drive
    import sdram_rfsh_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input  rf_state_e         state,
    input  logic              first,
    output logic [3:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic              done
);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

    // Decode the current step into one bus command
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        bank = '0;
        done = 1'b0;
        unique case (state)
            ST_PRE: begin
                if (first) begin
                    cmd  = CMD_PRE;
                    addr = ALL_BANKS;
                end
            end
            ST_REF_A, ST_REF_B: begin
                if (first) cmd = CMD_AREF;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_refresh_seq.sv
// Top of the periodic refresh sequencer. The interval timer raises
// ref_req; on an accepted grant the step sequencer runs precharge-all,
// then two auto-refresh commands, then a one-cycle done pulse.
// Assumes the arbiter keeps the bus granted for the whole episode.
module sdram_refresh_seq
    import sdram_rfsh_pkg::*;
#(
    parameter int PERIOD = 750,
    parameter int T_RP   = 2,
    parameter int T_RFC  = 5,
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              grant,
    output logic              ref_req,
    output logic [3:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic              done
);
    logic      accept;
    logic      first;
    rf_state_e state;

    rf_interval_timer #(.PERIOD(PERIOD)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (init_done),
        .accept    (accept),
        .req       (ref_req)
    );

    rf_step_fsm #(.T_RP(T_RP), .T_RFC(T_RFC)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .grant  (grant),
        .req    (ref_req),
        .accept (accept),
        .state  (state),
        .first  (first)
    );

    rf_cmd_drive #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)) u_drive (
        .state (state),
        .first (first),
        .cmd   (cmd),
        .addr  (addr),
        .bank  (bank),
        .done  (done)
    );

    // R4
    // pre_follows_accept_chk: an accepted grant yields precharge next cycle
    pre_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cmd == CMD_PRE) && addr[AP_BIT]);

    // R10
    // no_start_without_req_chk: a grant with no request never starts a precharge
    no_start_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !ref_req) |=> (cmd != CMD_PRE));

    // R7
    // done_pulse_chk: done never lasts two cycles
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sdram_refresh_seq_tb.sv
// Scoreboard bench: the grant driver pushes the expected per-cycle bus
// trace into a queue, and a negedge monitor pops and compares it.
module sdram_refresh_seq_tb;
    localparam int PERIOD = 60;
    localparam int T_RP   = 2;
    localparam int T_RFC  = 5;
    localparam int LAST   = T_RP + 2 * T_RFC;

    typedef struct {
        logic [3:0]  cmd;
        logic [11:0] addr;
        logic [1:0]  bank;
        logic        done;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_done = 1'b0;
    logic        grant = 1'b0;
    logic        ref_req;
    logic [3:0]  cmd;
    logic [11:0] addr;
    logic [1:0]  bank;
    logic        done;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   checking = 1'b0;
    bit   finished = 1'b0;
    exp_t q[$];

    // independent request model
    bit armed_m = 0;
    int el_m = 0;
    bit exp_req_m = 0;
    int busy_left = 0;

    always #10 clk = ~clk;

    sdram_refresh_seq #(.PERIOD(PERIOD), .T_RP(T_RP), .T_RFC(T_RFC)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .grant(grant),
        .ref_req(ref_req), .cmd(cmd), .addr(addr), .bank(bank), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Model of the request timing taken from R2, R3, R9, R11
    always @(posedge clk) begin
        bit tick, start;
        if (!rst_n) begin
            armed_m = 0; el_m = 0; exp_req_m = 0; busy_left = 0;
        end else begin
            tick = 0;
            if (!armed_m) begin
                if (init_done) begin armed_m = 1; el_m = 0; end
            end else begin
                el_m++;
                if (el_m == PERIOD) begin el_m = 0; tick = 1; end
            end
            start = grant && exp_req_m && (busy_left == 0);
            if (busy_left > 0) busy_left--;
            if (start) busy_left = LAST + 1;
            if (tick) exp_req_m = 1;
            else if (start) exp_req_m = 0;
        end
    end

    // Monitor: compare the bus against the queued trace, idle NOP otherwise
    always @(negedge clk) begin
        exp_t e;
        if (checking) begin
            if (q.size() > 0) e = q.pop_front();
            else e = '{cmd: 4'b0111, addr: 12'h0, bank: 2'b0, done: 1'b0, tag: "R8"};
            chk(cmd == e.cmd, e.tag, "cmd", cmd, e.cmd);
            chk(addr == e.addr, e.tag, "addr", addr, e.addr);
            chk(bank == e.bank, e.tag, "bank", bank, e.bank);
            chk(done == e.done, e.tag, "done", done, e.done);
            chk(ref_req == exp_req_m, "R3", "ref_req", ref_req, exp_req_m);
        end
    end

    // Driver: one-cycle grant; push the expected episode when it should start
    task automatic grant_pulse(input bit expect_start);
        #1 grant = 1'b1;
        if (expect_start) begin
            for (int i = 0; i <= LAST; i++) begin
                exp_t e;
                e = '{cmd: 4'b0111, addr: 12'h0, bank: 2'b0, done: 1'b0, tag: "R8"};
                if (i == 0) begin e.cmd = 4'b0010; e.addr = 12'h400; e.tag = "R4"; end
                else if (i == T_RP) begin e.cmd = 4'b0001; e.tag = "R5"; end
                else if (i == T_RP + T_RFC) begin e.cmd = 4'b0001; e.tag = "R6"; end
                else if (i == LAST) begin e.done = 1'b1; e.tag = "R7"; end
                q.push_back(e);
            end
        end
        @(negedge clk);
        #1 grant = 1'b0;
    endtask

    task automatic wait_el(input int v);
        do @(negedge clk); while (el_m != v);
    endtask

    task automatic wait_req();
        do @(negedge clk); while (!exp_req_m);
    endtask

    initial begin
        #(20 * 20000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cmd == 4'b0111, "R1", "cmd", cmd, 4'b0111);
        chk(addr == 12'h0 && bank == 2'b0, "R1", "addr/bank", {addr, bank}, 0);
        chk(!done && !ref_req, "R1", "done/ref_req", {done, ref_req}, 0);
        #1 rst_n = 1'b1;
        checking = 1'b1;

        repeat (50) @(negedge clk);
        chk(ref_req == 1'b0, "R2", "ref_req before init", ref_req, 0);
        #1 init_done = 1'b1;
        @(negedge clk);
        #1 init_done = 1'b0;
        wait_el(PERIOD - 1);
        chk(ref_req == 1'b0, "R2", "ref_req one edge early", ref_req, 0);
        @(negedge clk);
        chk(ref_req == 1'b1, "R2", "ref_req at PERIOD", ref_req, 1);

        // R3 request holds while ungranted, then a normal episode
        repeat (10) @(negedge clk);
        chk(ref_req == 1'b1, "R3", "ref_req held", ref_req, 1);
        grant_pulse(1);
        chk(ref_req == 1'b0, "R3", "ref_req cleared", ref_req, 0);
        repeat (16) @(negedge clk);

        // R10 grant without a request
        grant_pulse(0);
        chk(cmd == 4'b0111, "R10", "cmd after stray grant", cmd, 4'b0111);
        chk(ref_req == 1'b0, "R10", "ref_req after stray grant", ref_req, 0);

        // R9 terminal count inside an episode, then a grant while busy
        wait_req();
        wait_el(PERIOD - 5);
        grant_pulse(1);
        repeat (6) @(negedge clk);
        grant_pulse(0);
        chk(ref_req == 1'b1, "R9", "ref_req after busy grant", ref_req, 1);
        repeat (8) @(negedge clk);

        // R11 terminal count and accepted grant on the same edge
        wait_el(PERIOD - 1);
        grant_pulse(1);
        chk(cmd == 4'b0010, "R11", "cmd on collision", cmd, 4'b0010);
        chk(ref_req == 1'b1, "R11", "ref_req on collision", ref_req, 1);
        repeat (14) @(negedge clk);

        // R4 clear the request left by the collision
        grant_pulse(1);
        chk(cmd == 4'b0010 && addr == 12'h400, "R4", "precharge-all", {cmd, addr}, {4'b0010, 12'h400});
        repeat (16) @(negedge clk);
        finish_run();
    end

endmodule